// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block is the device end of a three-wire configuration port. The host drives a serial clock and a latch-enable strobe and shares one bidirectional data line with the device. Each 16-bit frame carries a 7-bit register address, a direction flag and one data byte. The strobe splits the frame into two phases. The address and the flag are shifted while the strobe is low. The byte follows with the strobe high. A write frame stores the byte into a bank of 36 eight-bit registers. A read frame turns the data line around and shifts the addressed register back to the host.

All three port inputs are brought into the system clock domain through a two-stage synchroniser, and edges are found from the synchronised copies. Every register is presented on a flat parallel bus for the rest of the chip. Each committed write also raises a one-cycle pulse that carries the target address. The block has a synchronous active-high reset.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, every register reads 0x00 on `regs_o`, and `ser_dat_oe_o` and `wr_pulse_o` are low.
- R2: A write frame stores its byte in the addressed register. The frame is sent with the strobe low for 7 address bits (most significant first) and a direction bit of 1, then with the strobe high for 8 data bits (most significant first). All bits are taken on falling serial-clock edges. Register `a` appears on `regs_o[a*8 +: 8]`.
- R3: The byte is committed only after the D0 bit has been taken, and no register changes before that. `wr_pulse_o` is high for exactly one system cycle and carries the address on `wr_addr_o`. The register shows the new value on the cycle after the pulse.
- R4: A read frame (direction bit 0) drives the addressed register onto `ser_dat_o`, most significant bit first. Each bit is valid before the falling edge of its data slot. A read changes no register.
- R5: `ser_dat_oe_o` is high only during the 8 data slots of a read frame. It is never high during a write frame, and it is low again once the D0 slot has been taken.
- R6: Frames with an address of 36 or more change no register and give no write pulse. A read from such an address returns 0x00.
- R7: If the strobe rises after 1 to 7 address-phase bits have been shifted, the partial frame is discarded. The next frame is then decoded from its first bit.
- R8: `wr_pulse_o` rises no later than 4 system clock cycles after the serial clock falls for D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the host, idle high |
| ser_ale_i | input | 1 | Latch-enable strobe: low for the address phase, high for the data phase |
| ser_dat_i | input | 1 | Data line as seen at the pad |
| ser_dat_o | output | 1 | Read data driven toward the pad |
| ser_dat_oe_o | output | 1 | Output enable for the data pad |
| wr_pulse_o | output | 1 | One-cycle pulse on each committed write |
| wr_addr_o | output | 7 | Address of the committed write |
| regs_o | output | 288 | All registers, register a at bits a*8+7 down to a*8 |

## Verification
The assertions assume that the serial clock's high and low phases each last several system cycles. They also assume that the data line and the strobe change only while the serial clock is high and stay steady over each falling edge. Under these conditions the synchronised copies see a clean falling edge and the matching data bit. The bench holds each serial half-period for 8 system cycles. It changes data and strobe only while the serial clock is high, so every property sees the orderly edges that it is written for.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 8;
    localparam int NUM_REGS    = 36;
    localparam int SYNC_STAGES = 2;
    localparam int SLOTS_MAX   = (DATA_W > ADDR_W + 1) ? DATA_W : ADDR_W + 1;
    localparam int CNT_W       = $clog2(SLOTS_MAX);

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_in_bank(input logic [ADDR_W-1:0] a, input int nregs);
        return int'(a) < nregs;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_ctl.sv
module cfg_frame_ctl
    import cfgport_pkg::*;
#(
    parameter int NREGS = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              ale_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              dout_o,
    output logic              doe_o,
    output wr_req_t           wr_o
);
    localparam logic [CNT_W-1:0] RW_SLOT   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] dout_q;
    logic              rw_q;
    logic              doe_q;
    logic              sclk_d;
    logic              ale_d;
    wr_req_t           wr_q;

    logic sclk_fall, ale_rise;
    assign sclk_fall = sclk_d & ~sclk_i;
    assign ale_rise  = ~ale_d & ale_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            addr_q  <= '0;
            din_q   <= '0;
            dout_q  <= '0;
            rw_q    <= 1'b0;
            doe_q   <= 1'b0;
            sclk_d  <= 1'b1;
            ale_d   <= 1'b1;
            wr_q    <= '0;
        end else begin
            sclk_d   <= sclk_i;
            ale_d    <= ale_i;
            wr_q.vld <= 1'b0;
            unique case (phase_q)
                PH_ADDR: begin
                    if (ale_rise && cnt_q != '0) begin
                        cnt_q <= '0;
                    end else if (sclk_fall && !ale_i) begin
                        if (cnt_q == RW_SLOT) begin
                            rw_q    <= din_i;
                            phase_q <= PH_DATA;
                            cnt_q   <= '0;
                            if (!din_i) begin
                                dout_q <= rd_data_i;
                                doe_q  <= 1'b1;
                            end
                        end else begin
                            addr_q <= {addr_q[ADDR_W-2:0], din_i};
                            cnt_q  <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                PH_DATA: begin
                    if (sclk_fall && ale_i) begin
                        din_q  <= {din_q[DATA_W-2:0], din_i};
                        dout_q <= {dout_q[DATA_W-2:0], 1'b0};
                        if (cnt_q == LAST_DATA) begin
                            phase_q <= PH_ADDR;
                            cnt_q   <= '0;
                            doe_q   <= 1'b0;
                            if (rw_q && addr_in_bank(addr_q, NREGS)) begin
                                wr_q <= '{vld: 1'b1, addr: addr_q,
                                          data: {din_q[DATA_W-2:0], din_i}};
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: phase_q <= PH_ADDR;
            endcase
        end
    end

    assign rd_addr_o = addr_q;
    assign dout_o    = dout_q[DATA_W-1];
    assign doe_o     = doe_q;
    assign wr_o      = wr_q;

    // R5: output enable only inside the data phase of a read
    a_r5_oe_read_only: assert property (@(posedge clk) disable iff (rst)
        doe_q |-> (phase_q == PH_DATA && !rw_q));

    // R5: enable drops only when a data slot is taken
    a_r5_oe_release: assert property (@(posedge clk) disable iff (rst)
        $fell(doe_q) |-> $past(sclk_fall));

    // R6: no write request leaves for an address outside the bank
    a_r6_no_write_out_of_range: assert property (@(posedge clk) disable iff (rst)
        wr_q.vld |-> addr_in_bank(wr_q.addr, NREGS));

    // R3: write request lasts a single cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_q.vld |=> !wr_q.vld);

    // R7: strobe rising mid-address discards the partial frame
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ADDR && cnt_q != '0 && ale_rise) |=> (phase_q == PH_ADDR && cnt_q == '0));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfgport_pkg::*;
#(
    parameter int NREGS = NUM_REGS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic [NREGS*DATA_W-1:0] regs_o
);
    logic [DATA_W-1:0] mem_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (wr_i.vld && wr_i.addr == ADDR_W'(g))
                mem_q[g] <= wr_i.data;
        end
        assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = mem_q[i];
        end
    end

    // R2: a write request lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_i.vld |=> regs_o[$past(wr_i.addr)*DATA_W +: DATA_W] == $past(wr_i.data));

    // R4: without a write request no register moves
    a_r4_bank_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_i.vld |=> $stable(regs_o));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgport_pkg::*;
#(
    parameter int NREGS  = NUM_REGS,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_clk_i,
    input  logic                    ser_ale_i,
    input  logic                    ser_dat_i,
    output logic                    ser_dat_o,
    output logic                    ser_dat_oe_o,
    output logic                    wr_pulse_o,
    output logic [ADDR_W-1:0]       wr_addr_o,
    output logic [NREGS*DATA_W-1:0] regs_o
);
    localparam int         NSIG    = 3;
    localparam logic [2:0] IDLE_HI = 3'b011;

    logic [NSIG-1:0] raw, synced;
    assign raw = {ser_dat_i, ser_ale_i, ser_clk_i};

    for (genvar s = 0; s < NSIG; s++) begin : g_sync
        cfg_sync #(.STAGES(STAGES), .RST_VAL(IDLE_HI[s])) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (raw[s]),
            .sync_o  (synced[s])
        );
    end

    wr_req_t           wr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    cfg_frame_ctl #(.NREGS(NREGS)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (synced[0]),
        .ale_i     (synced[1]),
        .din_i     (synced[2]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .dout_o    (ser_dat_o),
        .doe_o     (ser_dat_oe_o),
        .wr_o      (wr)
    );

    cfg_reg_bank #(.NREGS(NREGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    assign wr_pulse_o = wr.vld;
    assign wr_addr_o  = wr.addr;

    // R1: outputs quiet in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!ser_dat_oe_o && !wr_pulse_o && regs_o == '0));
endmodule

// File: tb/tb_cfg_serial_slave.sv
module tb_cfg_serial_slave;
    localparam int HP = 8;
    localparam int NR = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk_i = 1'b1, ser_ale_i = 1'b1, ser_dat_i = 1'b1;
    logic ser_dat_o, ser_dat_oe_o, wr_pulse_o;
    logic [6:0] wr_addr_o;
    logic [NR*8-1:0] regs_o;

    always #2.5 clk = ~clk;

    cfg_serial_slave dut (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_ale_i(ser_ale_i),
        .ser_dat_i(ser_dat_i), .ser_dat_o(ser_dat_o), .ser_dat_oe_o(ser_dat_oe_o),
        .wr_pulse_o(wr_pulse_o), .wr_addr_o(wr_addr_o), .regs_o(regs_o)
    );

    int checks = 0, errors = 0, pulses = 0, dbl = 0;
    logic pulse_d = 1'b0;
    logic [7:0] model [NR];

    always @(negedge clk) begin
        if (wr_pulse_o) pulses++;
        if (wr_pulse_o && pulse_d) dbl++;
        pulse_d = wr_pulse_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] model_flat();
        logic [NR*8-1:0] f;
        for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic sbit(input logic b, output logic o, output logic oe);
        @(negedge clk); ser_dat_i = b;
        repeat (HP) @(negedge clk);
        o = ser_dat_o; oe = ser_dat_oe_o;
        ser_clk_i = 1'b0;
        repeat (HP) @(negedge clk);
        ser_clk_i = 1'b1;
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rw);
        logic o, oe;
        @(negedge clk); ser_ale_i = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 6; i >= 0; i--) sbit(a[i], o, oe);
        sbit(rw, o, oe);
        repeat (HP) @(negedge clk);
        ser_ale_i = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic frame(input logic [6:0] a, input logic rw, input logic [7:0] d,
                         output logic [7:0] rd, output int oe_hits);
        logic o, oe;
        oe_hits = 0;
        addr_phase(a, rw);
        for (int i = 7; i >= 0; i--) begin
            sbit(rw ? d[i] : 1'b1, o, oe);
            rd[i] = o;
            oe_hits += int'(oe);
        end
        repeat (2 * HP) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(regs_o == '0, "R1 regs zero", 32'(regs_o[31:0]), 0);
        chk(ser_dat_oe_o == 1'b0, "R1 oe low", 32'(ser_dat_oe_o), 0);
        chk(wr_pulse_o == 1'b0, "R1 pulse low", 32'(wr_pulse_o), 0);
    endtask

    task automatic t_write_read();
        logic [7:0] rd; int hits;
        frame(7'd3, 1'b1, 8'h5A, rd, hits); model[3] = 8'h5A;
        chk(regs_o[3*8 +: 8] == 8'h5A, "R2 write reg3", 32'(regs_o[3*8 +: 8]), 32'h5A);
        chk(hits == 0, "R5 oe during write", 32'(hits), 0);
        frame(7'd17, 1'b1, 8'hA5, rd, hits); model[17] = 8'hA5;
        chk(regs_o == model_flat(), "R2 second write bank", 32'(regs_o[17*8 +: 8]), 32'hA5);
        frame(7'd3, 1'b0, 8'h00, rd, hits);
        chk(rd == 8'h5A, "R4 read reg3", 32'(rd), 32'h5A);
        chk(hits == 8, "R5 oe in read slots", 32'(hits), 8);
        chk(ser_dat_oe_o == 1'b0, "R5 oe released", 32'(ser_dat_oe_o), 0);
        chk(regs_o == model_flat(), "R4 read leaves bank", 32'(regs_o[3*8 +: 8]), 32'h5A);
        frame(7'd17, 1'b0, 8'h00, rd, hits);
        chk(rd == 8'hA5, "R4 read reg17", 32'(rd), 32'hA5);
    endtask

    task automatic t_commit();
        logic o, oe; int k; int p0;
        logic [7:0] d = 8'hC3;
        addr_phase(7'd10, 1'b1);
        for (int i = 7; i >= 1; i--) sbit(d[i], o, oe);
        @(negedge clk); ser_dat_i = d[0];
        repeat (HP) @(negedge clk);
        chk(regs_o[10*8 +: 8] == 8'h00, "R3 no commit before D0", 32'(regs_o[10*8 +: 8]), 0);
        p0 = pulses;
        ser_clk_i = 1'b0;
        k = 0;
        while (!wr_pulse_o && k < 12) begin @(negedge clk); k++; end
        chk(k >= 1 && k <= 4, "R8 pulse latency", 32'(k), 4);
        chk(wr_addr_o == 7'd10, "R3 pulse address", 32'(wr_addr_o), 10);
        @(negedge clk);
        chk(regs_o[10*8 +: 8] == 8'hC3, "R3 committed value", 32'(regs_o[10*8 +: 8]), 32'hC3);
        model[10] = 8'hC3;
        repeat (HP) @(negedge clk);
        ser_clk_i = 1'b1;
        repeat (HP) @(negedge clk);
        chk(pulses - p0 == 1 && dbl == 0, "R3 one-cycle pulse", 32'(pulses - p0), 1);
    endtask

    task automatic t_bounds();
        logic [7:0] rd; int hits; int p0;
        frame(7'd35, 1'b1, 8'hFF, rd, hits); model[35] = 8'hFF;
        chk(regs_o[35*8 +: 8] == 8'hFF, "R6 last register", 32'(regs_o[35*8 +: 8]), 32'hFF);
        p0 = pulses;
        frame(7'd36, 1'b1, 8'h77, rd, hits);
        chk(pulses == p0, "R6 no pulse at 36", 32'(pulses - p0), 0);
        chk(regs_o == model_flat(), "R6 bank unchanged at 36", 32'(regs_o[31:0]), 32'(model_flat()));
        frame(7'd127, 1'b1, 8'h11, rd, hits);
        chk(regs_o == model_flat() && pulses == p0, "R6 bank unchanged at 127", 32'(pulses - p0), 0);
        frame(7'd36, 1'b0, 8'h00, rd, hits);
        chk(rd == 8'h00, "R6 read 36 zero", 32'(rd), 0);
        frame(7'd127, 1'b0, 8'h00, rd, hits);
        chk(rd == 8'h00, "R6 read 127 zero", 32'(rd), 0);
    endtask

    task automatic t_abort();
        logic o, oe; logic [7:0] rd; int hits;
        @(negedge clk); ser_ale_i = 1'b0;
        repeat (HP) @(negedge clk);
        sbit(1'b1, o, oe); sbit(1'b1, o, oe); sbit(1'b0, o, oe);
        repeat (HP) @(negedge clk);
        ser_ale_i = 1'b1;
        repeat (2 * HP) @(negedge clk);
        frame(7'd5, 1'b1, 8'h21, rd, hits); model[5] = 8'h21;
        chk(regs_o[5*8 +: 8] == 8'h21, "R7 frame after abort", 32'(regs_o[5*8 +: 8]), 32'h21);
        chk(regs_o == model_flat(), "R7 no stray write", 32'(regs_o[31:0]), 32'(model_flat()));
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_commit();
        t_bounds();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule